// File: doc/BRIEF.md
# Interrupt Request Gate with Service Lockout

This block sits between the interrupt sources of a small microcontroller core and the core's single interrupt input. Software sees two byte-wide registers on a plain register bus: a control register and a mask register. The control register holds a global enable and an in-service flag. The mask register has one bit for each of six register modules and one bit that covers all system sources. The block forwards a request only when interrupts are globally on, no service is in progress, and some pending source has its mask bit set.

The in-service flag locks out further requests once the core acknowledges an interrupt. The core's return strobe releases it. Software may also clear the flag early from inside a handler, which permits nesting. The request output is a flop, so it follows its inputs one clock later.

The bus has no handshake: a write takes effect at the clock edge on which `bus_we` is high, and `bus_rdata` follows `bus_addr` without a clock. There is no data stream and no back-pressure. Every pin is a plain control or status signal.

Top module: `irq_gate`

## Requirements
- R1: After reset, the control register and the mask register both read 00h and `irq_req` is 0.
- R2: The control register is at address 0. Bit 0 is the global enable and bit 1 is the in-service flag. Bits 7:2 read 0, and writing 1s to them has no visible effect.
- R3: The mask register is at address 1. Bits 5:0 enable module pending inputs 5 to 0, one bit per module, and bit 7 enables `sys_pend`. Bit 6 reads 0, and setting it lets no source through.
- R4: `irq_req` is 1 in the cycle after a clock edge at which the global enable was 1, the in-service flag was 0, no acknowledge occurred, and at least one pending input had its mask bit set. Otherwise `irq_req` is 0 in that cycle, so the output lags its causes by exactly one clock.
- R5: While the global enable is 0, `irq_req` stays 0 whatever the masks and pending inputs are.
- R6: An acknowledge strobe sets the in-service flag. `irq_req` is 0 in the cycle after the acknowledge and stays 0 while the flag is 1.
- R7: A return strobe with no acknowledge in the same cycle clears the in-service flag.
- R8: A control-register write with no strobe in the same cycle loads the in-service flag from write-data bit 1. Writing 0 re-enables requests during service, which is how nesting is done.
- R9: An acknowledge in the same cycle as a control-register write or a return strobe leaves the in-service flag at 1.
- R10: A return strobe in the same cycle as a control-register write leaves the in-service flag at 0, whatever write-data bit 1 is. The write still loads the global enable.
- R11: Addresses other than 0 and 1 read 00h, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| mod_pend | input | 6 | Pending flags of register modules 5 to 0 |
| sys_pend | input | 1 | Pending flag of the system sources |
| ack_stb | input | 1 | One-cycle acknowledge from the core |
| ret_stb | input | 1 | One-cycle return-from-interrupt or pop-interrupt strobe |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
The bench builds the block with its default parameters: six modules, a 4-bit address and the two registers at addresses 0 and 1. These values let the mask table exercise every module bit, the system bit and the reserved bit 6. The spare addresses 2 to 15 let the bench check that writes there change nothing. Directed sequences cover the one-clock request latency, lockout on acknowledge, release by the return strobe and by a software write, and every same-cycle collision among acknowledge, return and a control-register write.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int REG_W      = 8;
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_IS_BIT = 1;
  localparam int MSK_SYS_BIT = REG_W - 1;
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wr_en_bit,
  input  logic wr_is_bit,
  input  logic ack_stb,
  input  logic ret_stb,
  output logic glob_en,
  output logic in_svc
);
  logic in_svc_d;

  // priority order: acknowledge, then return, then software write
  always_comb begin
    if (ack_stb)      in_svc_d = 1'b1;
    else if (ret_stb) in_svc_d = 1'b0;
    else if (wr_ctl)  in_svc_d = wr_is_bit;
    else              in_svc_d = in_svc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      in_svc  <= 1'b0;
    end else begin
      if (wr_ctl) glob_en <= wr_en_bit;
      in_svc <= in_svc_d;
    end
  end

  // R6
  ack_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> in_svc);
  // R7
  ret_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && !ack_stb) |=> !in_svc);
  // R8
  sw_loads_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !ack_stb && !ret_stb) |=> (in_svc == $past(wr_is_bit)));
  // R2
  enable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(glob_en));
endmodule

// File: rtl/irq_gate_mask.sv
module irq_gate_mask
  import irq_gate_pkg::*;
#(
  parameter int NUM_MOD = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_msk,
  input  reg_t               wdata,
  input  logic [NUM_MOD-1:0] mod_pend,
  input  logic               sys_pend,
  output reg_t               mask_q,
  output logic               any_hit
);
  localparam reg_t MOD_BITS = reg_t'((1 << NUM_MOD) - 1);
  localparam reg_t WR_BITS  = MOD_BITS | (reg_t'(1) << MSK_SYS_BIT);

  logic [NUM_MOD-1:0] mod_hit;
  logic               sys_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_msk) mask_q <= wdata & WR_BITS;
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    assign mod_hit[m] = mod_pend[m] & mask_q[m];
  end
  assign sys_hit = sys_pend & mask_q[MSK_SYS_BIT];
  assign any_hit = (|mod_hit) | sys_hit;

  // R3
  mask_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_msk |=> $stable(mask_q));
endmodule

// File: rtl/irq_gate_req.sv
module irq_gate_req (
  input  logic clk,
  input  logic rst_n,
  input  logic glob_en,
  input  logic in_svc,
  input  logic any_hit,
  input  logic ack_stb,
  output logic irq_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= glob_en & ~in_svc & any_hit & ~ack_stb;
  end

  // R5
  off_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !irq_req);
  // R6
  service_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc || ack_stb) |=> !irq_req);
  // R4
  req_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(any_hit));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_MOD  = 6,
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 0,
  parameter int MSK_ADDR = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NUM_MOD-1:0] mod_pend,
  input  logic               sys_pend,
  input  logic               ack_stb,
  input  logic               ret_stb,
  output logic               irq_req
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(MSK_ADDR);

  logic sel_ctl, sel_msk;
  logic glob_en, in_svc, any_hit;
  reg_t mask_q;

  assign sel_ctl = (bus_addr == A_CTL);
  assign sel_msk = (bus_addr == A_MSK);

  irq_gate_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (bus_we & sel_ctl),
    .wr_en_bit (bus_wdata[CTL_EN_BIT]),
    .wr_is_bit (bus_wdata[CTL_IS_BIT]),
    .ack_stb   (ack_stb),
    .ret_stb   (ret_stb),
    .glob_en   (glob_en),
    .in_svc    (in_svc)
  );

  irq_gate_mask #(.NUM_MOD(NUM_MOD)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_msk   (bus_we & sel_msk),
    .wdata    (bus_wdata),
    .mod_pend (mod_pend),
    .sys_pend (sys_pend),
    .mask_q   (mask_q),
    .any_hit  (any_hit)
  );

  irq_gate_req u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .glob_en (glob_en),
    .in_svc  (in_svc),
    .any_hit (any_hit),
    .ack_stb (ack_stb),
    .irq_req (irq_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctl) begin
      bus_rdata[CTL_EN_BIT] = glob_en;
      bus_rdata[CTL_IS_BIT] = in_svc;
    end else if (sel_msk) begin
      bus_rdata = mask_q;
    end
  end

  // R11
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ctl && !sel_msk) |-> (bus_rdata == '0));
  // R2
  ctl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctl |-> (bus_rdata[REG_W-1:2] == '0));
endmodule

// File: tb/irq_gate_tb_top.sv
`timescale 1ns/1ps
module irq_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] mod_pend = '0;
  logic       sys_pend = 1'b0;
  logic       ack_stb = 1'b0;
  logic       ret_stb = 1'b0;
  logic       irq_req;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_gate dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_pend(mod_pend),
    .sys_pend(sys_pend), .ack_stb(ack_stb), .ret_stb(ret_stb), .irq_req(irq_req)
  );

  // {enable[16], mask[15:8], module pend[7:2], system pend[1], expected request[0]}
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 8'h01, 6'h01, 1'b0, 1'b1},
    {1'b1, 8'h01, 6'h02, 1'b0, 1'b0},
    {1'b1, 8'h20, 6'h20, 1'b0, 1'b1},
    {1'b0, 8'hFF, 6'h3F, 1'b1, 1'b0},
    {1'b1, 8'h80, 6'h00, 1'b1, 1'b1},
    {1'b1, 8'h80, 6'h3F, 1'b0, 1'b0},
    {1'b1, 8'h3F, 6'h00, 1'b1, 1'b0},
    {1'b1, 8'h00, 6'h3F, 1'b1, 1'b0},
    {1'b1, 8'h40, 6'h00, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic a, input logic r);
    ack_stb = a; ret_stb = r;
    @(negedge clk);
    ack_stb = 1'b0; ret_stb = 1'b0;
  endtask

  initial begin
    #100000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 control after reset", 4'd0, 8'h00);
    rd("R1 mask after reset", 4'd1, 8'h00);
    check("R1 request after reset", {7'd0, irq_req}, 8'h00);

    wr(4'd0, 8'hFD);
    rd("R2 control spare bits", 4'd0, 8'h01);
    wr(4'd1, 8'hFF);
    rd("R3 mask bit 6 reads 0", 4'd1, 8'hBF);

    // R4 R5 R3 mask table
    for (int i = 0; i < 9; i++) begin
      wr(4'd0, {7'd0, VEC[i][16]});
      wr(4'd1, VEC[i][15:8]);
      mod_pend = VEC[i][7:2]; sys_pend = VEC[i][1];
      @(negedge clk);
      check($sformatf("R4 R5 vector %0d", i), {7'd0, irq_req}, {7'd0, VEC[i][0]});
      mod_pend = '0; sys_pend = 1'b0;
      @(negedge clk);
    end

    // R4 one-clock latency
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h01);
    @(negedge clk);
    mod_pend = 6'h01;
    #1;
    check("R4 request before edge", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check("R4 request after edge", {7'd0, irq_req}, 8'h01);

    // R6 acknowledge lockout
    pulse(1'b1, 1'b0);
    rd("R6 flag set by ack", 4'd0, 8'h03);
    check("R6 request after ack", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check("R6 request while in service", {7'd0, irq_req}, 8'h00);

    // R7 return releases
    pulse(1'b0, 1'b1);
    rd("R7 flag cleared by return", 4'd0, 8'h01);
    @(negedge clk);
    check("R7 request after return", {7'd0, irq_req}, 8'h01);

    // R8 software clear for nesting
    pulse(1'b1, 1'b0);
    wr(4'd0, 8'h01);
    rd("R8 flag cleared by write", 4'd0, 8'h01);
    @(negedge clk);
    check("R8 nested request", {7'd0, irq_req}, 8'h01);
    wr(4'd0, 8'h03);
    rd("R8 flag set by write", 4'd0, 8'h03);
    wr(4'd0, 8'h01);

    // R9 acknowledge wins
    ack_stb = 1'b1;
    wr(4'd0, 8'h01);
    ack_stb = 1'b0;
    rd("R9 ack beats write", 4'd0, 8'h03);
    pulse(1'b1, 1'b1);
    rd("R9 ack beats return", 4'd0, 8'h03);

    // R10 return beats write
    ret_stb = 1'b1;
    wr(4'd0, 8'h02);
    ret_stb = 1'b0;
    rd("R10 return beats write", 4'd0, 8'h00);

    // R11 unmapped addresses
    wr(4'd0, 8'h01);
    wr(4'd5, 8'hFF);
    wr(4'd15, 8'h00);
    rd("R11 unmapped read", 4'd5, 8'h00);
    rd("R11 control untouched", 4'd0, 8'h01);
    rd("R11 mask untouched", 4'd1, 8'h01);

    mod_pend = '0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule